// File: doc/BRIEF.md
# Predicate Mask Lookup Table

This block turns the destination register of an operation into the element mask that governs that operation. A small content-addressed table holds per-register predication entries. Each entry is keyed by a register number together with a flag that picks the integer or the floating-point register class. A lookup names a destination register and a class, and the table is searched for a matching entry.

If an entry matches and is enabled, the mask comes from the integer register file. The register read is the one named by the entry's source index, not the instruction's register number. The fetched value can be inverted bit for bit, and the entry's zeroing flag is returned with it. Without an enabled match the operation runs unmasked, with an all-ones mask and no zeroing. The response is registered and appears one clock after the request.

Entries are loaded through a slot-addressed write port. The stack-pointer register (number 2) may never be redirected: a write that keys an entry on register 2 with any other source index is refused and flagged.

Top module: `pred_mask_lookup`

## Requirements
- R1: After synchronous reset every table slot is empty, `rsp_valid` is low and `wr_reject` is low.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_req` high, and low otherwise.
- R3: A lookup with no valid matching entry, or whose matching entry has its enable bit clear, returns a mask of all ones and `rsp_zero` = 0.
- R4: For an enabled matching entry, `rf_rd_idx` shows the entry's source index during the request cycle, and the mask is the integer register at that index.
- R5: When the enabled matching entry has its invert bit set, every bit of the fetched register value is complemented in the returned mask.
- R6: For an enabled matching entry, `rsp_zero` equals the entry's zeroing bit.
- R7: An entry matches only when both its key and its class flag (`0` = integer, `1` = floating point) equal those of the lookup. Integer and floating-point entries for the same register number are independent.
- R8: A write with `wr_valid` = 1, `wr_key` = 2 and `wr_src` not equal to 2 is refused. The slot keeps its old contents, and `wr_reject` pulses high in the cycle after the write. An accepted write leaves `wr_reject` low.
- R9: A source index of 0 reads as zero whatever the register file returns. The mask is then all zeros, or all ones when the entry is inverted.
- R10: When several valid entries match the same key and class, the lowest-numbered slot decides the result.
- R11: A write with `wr_valid` = 0 empties the slot, so later lookups of its key fall back to the R3 result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write one table slot this cycle |
| wr_slot | input | 4 | Slot number to write |
| wr_valid | input | 1 | Slot holds a live entry after the write |
| wr_key | input | 5 | Destination register number the entry is keyed on |
| wr_is_fp | input | 1 | Class of the key: 0 integer, 1 floating point |
| wr_src | input | 5 | Integer register that supplies the mask |
| wr_enable | input | 1 | Predication enabled for this key |
| wr_invert | input | 1 | Complement the fetched mask |
| wr_zero | input | 1 | Masked-off elements are zeroed |
| wr_reject | output | 1 | Previous cycle's write was refused (stack-pointer rule) |
| lk_req | input | 1 | Lookup request |
| lk_key | input | 5 | Destination register number of the operation |
| lk_is_fp | input | 1 | Class of the operation: 0 integer, 1 floating point |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_mask | output | 32 | Predicate mask |
| rsp_zero | output | 1 | Zeroing flag for masked-off elements |
| rf_rd_idx | output | 5 | Integer register file read index |
| rf_rd_data | input | 32 | Integer register file read data, combinational from rf_rd_idx |

## Verification
Suppose the table state goes wrong: a stored field is dropped, or a refused stack-pointer write lands anyway. This shows up on `rsp_mask` and `rsp_zero` in the response that follows the very next lookup of that key, one clock after the request. A wrong priority choice appears only when duplicate keys are live, so the bench installs duplicates deliberately. The bench repeatedly sweeps every register number in both classes against a set of table loads. Each response is compared with a mask computed arithmetically from a register-file pattern, so a single corrupted slot or bit is caught within one sweep.

// File: rtl/pred_lut_pkg.sv
package pred_lut_pkg;

    localparam int NUM_SLOTS = 16;
    localparam int REG_W     = 5;
    localparam int DATA_W    = 32;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    localparam logic [REG_W-1:0] SP_REG   = REG_W'(2);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    typedef struct packed {
        logic             live;
        logic [REG_W-1:0] key;
        logic             is_fp;
        logic [REG_W-1:0] src;
        logic             enable;
        logic             invert;
        logic             zero;
    } slot_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] mask;
        logic              zero;
    } resp_t;

    // A live entry keyed on the stack pointer must point back at itself.
    function automatic logic sp_rule_broken(input slot_t s);
        return s.live && (s.key == SP_REG) && (s.src != SP_REG);
    endfunction

    function automatic logic keys_match(input slot_t s,
                                        input logic [REG_W-1:0] key,
                                        input logic is_fp);
        return s.live && (s.key == key) && (s.is_fp == is_fp);
    endfunction

endpackage

// File: rtl/pred_slot_table.sv
module pred_slot_table
    import pred_lut_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [SLOT_W-1:0]     wr_slot,
    input  slot_t                 wr_data,
    output logic                  wr_reject,
    output slot_t [NUM_SLOTS-1:0] slots
);

    logic refuse;

    always_comb begin
        refuse = wr_en && sp_rule_broken(wr_data);
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (wr_en && !refuse && (wr_slot == SLOT_W'(g))) begin
                slots[g] <= wr_data;
            end
        end

        // R8: no stored entry ever redirects the stack pointer
        a_r8_sp_never_redirected: assert property (@(posedge clk) disable iff (rst)
            !(slots[g].live && slots[g].key == SP_REG && slots[g].src != SP_REG));

        // R8: a refused write leaves the slot untouched
        a_r8_refused_slot_stable: assert property (@(posedge clk) disable iff (rst)
            (refuse && wr_slot == SLOT_W'(g)) |=> $stable(slots[g]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_reject <= 1'b0;
        end else begin
            wr_reject <= refuse;
        end
    end

    a_r8_reject_after_bad_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data.live && wr_data.key == SP_REG && wr_data.src != SP_REG)
        |=> wr_reject);

endmodule

// File: rtl/pred_slot_match.sv
module pred_slot_match
    import pred_lut_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  slot_t [NUM_SLOTS-1:0] slots,
    input  logic [REG_W-1:0]      lk_key,
    input  logic                  lk_is_fp,
    output logic                  hit,
    output slot_t                 hit_slot
);

    logic [NUM_SLOTS-1:0] cand;
    logic [NUM_SLOTS-1:0] grant;
    logic [NUM_SLOTS:0]   seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cand
        assign cand[g]     = keys_match(slots[g], lk_key, lk_is_fp);
        assign grant[g]    = cand[g] && !seen[g];
        assign seen[g + 1] = seen[g] || cand[g];
    end

    always_comb begin
        hit_slot = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (grant[i]) begin
                hit_slot = hit_slot | slots[i];
            end
        end
    end

    assign hit = seen[NUM_SLOTS];

    // R10: at most one slot wins the search
    a_r10_single_winner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R7: a hit always carries the requested key and class
    a_r7_hit_matches_key: assert property (@(posedge clk) disable iff (rst)
        hit |-> (hit_slot.key == lk_key && hit_slot.is_fp == lk_is_fp && hit_slot.live));

endmodule

// File: rtl/pred_mask_form.sv
module pred_mask_form
    import pred_lut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic              hit,
    input  slot_t             hit_slot,
    output logic [REG_W-1:0]  rf_rd_idx,
    input  logic [DATA_W-1:0] rf_rd_data,
    output resp_t             resp
);

    logic              use_pred;
    logic [DATA_W-1:0] fetched;
    resp_t             next_resp;

    always_comb begin
        use_pred  = hit && hit_slot.enable;
        rf_rd_idx = use_pred ? hit_slot.src : ZERO_REG;
        fetched   = (rf_rd_idx == ZERO_REG) ? '0 : rf_rd_data;

        next_resp.valid = lk_req;
        if (use_pred) begin
            next_resp.mask = hit_slot.invert ? ~fetched : fetched;
            next_resp.zero = hit_slot.zero;
        end else begin
            next_resp.mask = '1;
            next_resp.zero = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp <= '0;
        end else begin
            resp <= next_resp;
        end
    end

    // R2: response strobe follows the request by exactly one cycle
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> resp.valid);
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !resp.valid);

    // R3: unpredicated requests come back unmasked and non-zeroing
    a_r3_unpredicated_all_ones: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !(hit && hit_slot.enable)) |=> (resp.mask == '1 && !resp.zero));

    // R9: register zero as a source never lets read data through
    a_r9_zero_source: assert property (@(posedge clk) disable iff (rst)
        (lk_req && hit && hit_slot.enable && hit_slot.src == ZERO_REG)
        |=> (resp.mask == '0 || resp.mask == '1));

endmodule

// File: rtl/pred_mask_lookup.sv
module pred_mask_lookup
    import pred_lut_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [SLOT_W-1:0]       wr_slot,
    input  logic                    wr_valid,
    input  logic [REG_W-1:0]        wr_key,
    input  logic                    wr_is_fp,
    input  logic [REG_W-1:0]        wr_src,
    input  logic                    wr_enable,
    input  logic                    wr_invert,
    input  logic                    wr_zero,
    output logic                    wr_reject,
    input  logic                    lk_req,
    input  logic [REG_W-1:0]        lk_key,
    input  logic                    lk_is_fp,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_mask,
    output logic                    rsp_zero,
    output logic [REG_W-1:0]        rf_rd_idx,
    input  logic [DATA_W-1:0]       rf_rd_data
);

    slot_t                 wr_data;
    slot_t [NUM_SLOTS-1:0] slots;
    logic                  hit;
    slot_t                 hit_slot;
    resp_t                 resp;

    always_comb begin
        wr_data.live   = wr_valid;
        wr_data.key    = wr_key;
        wr_data.is_fp  = wr_is_fp;
        wr_data.src    = wr_src;
        wr_data.enable = wr_enable;
        wr_data.invert = wr_invert;
        wr_data.zero   = wr_zero;
    end

    pred_slot_table i_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .wr_data   (wr_data),
        .wr_reject (wr_reject),
        .slots     (slots)
    );

    pred_slot_match i_match (
        .clk      (clk),
        .rst      (rst),
        .slots    (slots),
        .lk_key   (lk_key),
        .lk_is_fp (lk_is_fp),
        .hit      (hit),
        .hit_slot (hit_slot)
    );

    pred_mask_form i_form (
        .clk        (clk),
        .rst        (rst),
        .lk_req     (lk_req),
        .hit        (hit),
        .hit_slot   (hit_slot),
        .rf_rd_idx  (rf_rd_idx),
        .rf_rd_data (rf_rd_data),
        .resp       (resp)
    );

    assign rsp_valid = resp.valid;
    assign rsp_mask  = resp.mask;
    assign rsp_zero  = resp.zero;

endmodule

// File: tb/test_pred_mask_lookup.sv
module test_pred_mask_lookup;

    localparam int NS = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_slot;
    logic        wr_valid;
    logic [4:0]  wr_key;
    logic        wr_is_fp;
    logic [4:0]  wr_src;
    logic        wr_enable;
    logic        wr_invert;
    logic        wr_zero;
    logic        wr_reject;
    logic        lk_req;
    logic [4:0]  lk_key;
    logic        lk_is_fp;
    logic        rsp_valid;
    logic [31:0] rsp_mask;
    logic        rsp_zero;
    logic [4:0]  rf_rd_idx;
    logic [31:0] rf_rd_data;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Bench copy of the table, updated only by writes the rules accept
    bit       m_live [NS];
    bit [4:0] m_key  [NS];
    bit       m_fp   [NS];
    bit [4:0] m_src  [NS];
    bit       m_en   [NS];
    bit       m_inv  [NS];
    bit       m_zero [NS];

    always #5 clk = ~clk;

    function automatic logic [31:0] rf_value(input logic [4:0] idx);
        return ({27'd0, idx} * 32'h0901_0203) ^ 32'h5A3C_0F81;
    endfunction

    // Register file with a deliberately nonzero value at index 0 (R9)
    assign rf_rd_data = rf_value(rf_rd_idx);

    pred_mask_lookup i_pred_mask_lookup (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_valid(wr_valid), .wr_key(wr_key),
        .wr_is_fp(wr_is_fp), .wr_src(wr_src), .wr_enable(wr_enable),
        .wr_invert(wr_invert), .wr_zero(wr_zero), .wr_reject(wr_reject),
        .lk_req(lk_req), .lk_key(lk_key), .lk_is_fp(lk_is_fp),
        .rsp_valid(rsp_valid), .rsp_mask(rsp_mask), .rsp_zero(rsp_zero),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_slot(input int slot, input bit live, input bit [4:0] key,
                              input bit fp, input bit [4:0] src, input bit en,
                              input bit inv, input bit zero);
        bit bad;
        bad = live && key == 5'd2 && src != 5'd2;
        @(negedge clk);
        wr_en = 1'b1; wr_slot = 4'(slot); wr_valid = live; wr_key = key;
        wr_is_fp = fp; wr_src = src; wr_enable = en; wr_invert = inv; wr_zero = zero;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 reject flag", {31'd0, wr_reject}, {31'd0, bad});
        if (!bad) begin
            m_live[slot] = live; m_key[slot] = key; m_fp[slot] = fp; m_src[slot] = src;
            m_en[slot] = en; m_inv[slot] = inv; m_zero[slot] = zero;
        end
    endtask

    task automatic expect_of(input bit [4:0] key, input bit fp,
                             output logic [31:0] mask, output logic zero,
                             output logic pred, output logic [4:0] idx);
        logic [31:0] raw;
        mask = '1; zero = 1'b0; pred = 1'b0; idx = 5'd0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (m_live[i] && m_key[i] == key && m_fp[i] == fp) begin
                pred = m_en[i];
                idx  = m_src[i];
            end
        end
        if (pred) begin
            for (int i = NS - 1; i >= 0; i--) begin
                if (m_live[i] && m_key[i] == key && m_fp[i] == fp) begin
                    zero = m_zero[i];
                    raw  = (m_src[i] == 5'd0) ? 32'd0 : rf_value(m_src[i]);
                    mask = m_inv[i] ? ~raw : raw;
                end
            end
        end
    endtask

    task automatic lookup(input bit [4:0] key, input bit fp, input string req);
        logic [31:0] em;
        logic        ez, ep;
        logic [4:0]  ei;
        expect_of(key, fp, em, ez, ep, ei);
        @(negedge clk);
        lk_req = 1'b1; lk_key = key; lk_is_fp = fp;
        #1;
        if (ep) check({req, " R4 read index"}, {27'd0, rf_rd_idx}, {27'd0, ei});
        @(negedge clk);
        lk_req = 1'b0;
        check({req, " R2 valid"}, {31'd0, rsp_valid}, 32'd1);
        check({req, " mask"}, rsp_mask, em);
        check({req, " R6 zero flag"}, {31'd0, rsp_zero}, {31'd0, ez});
    endtask

    task automatic sweep(input string req);
        for (int k = 0; k < 32; k++) begin
            for (int f = 0; f < 2; f++) begin
                lookup(5'(k), f[0], req);
            end
        end
    endtask

    initial begin
        #1500000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_live[i] = 0; m_key[i] = 0; m_fp[i] = 0; m_src[i] = 0;
            m_en[i] = 0; m_inv[i] = 0; m_zero[i] = 0;
        end
        rst = 1'b1; wr_en = 0; wr_slot = 0; wr_valid = 0; wr_key = 0; wr_is_fp = 0;
        wr_src = 0; wr_enable = 0; wr_invert = 0; wr_zero = 0;
        lk_req = 0; lk_key = 0; lk_is_fp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        check("R1 wr_reject after reset", {31'd0, wr_reject}, 32'd0);
        sweep("R1 R3 empty table");

        // R2: no strobe without a request
        @(negedge clk);
        check("R2 idle strobe", {31'd0, rsp_valid}, 32'd0);

        // R4 R5 R6 R7: plain, inverted, zeroing entries in both classes
        write_slot(0, 1, 5'd5,  0, 5'd7,  1, 0, 0);
        write_slot(1, 1, 5'd5,  1, 5'd9,  1, 1, 1);
        write_slot(2, 1, 5'd12, 0, 5'd31, 1, 1, 0);
        write_slot(3, 1, 5'd20, 1, 5'd3,  0, 1, 1);   // R3 disabled entry
        write_slot(4, 1, 5'd2,  0, 5'd2,  1, 0, 1);   // R8 legal stack-pointer entry
        write_slot(5, 1, 5'd0,  1, 5'd0,  1, 0, 1);   // R9 source zero
        write_slot(6, 1, 5'd1,  0, 5'd0,  1, 1, 0);   // R9 source zero inverted
        sweep("R4 R5 R7 config A");

        // R8: illegal stack-pointer writes, one of them over a live slot
        write_slot(7, 1, 5'd2, 1, 5'd6, 1, 0, 0);
        write_slot(4, 1, 5'd2, 0, 5'd0, 1, 1, 0);
        write_slot(8, 0, 5'd2, 0, 5'd9, 1, 0, 0);     // empty write is accepted
        lookup(5'd2, 0, "R8 slot kept");
        lookup(5'd2, 1, "R8 no entry");

        // R10: duplicates, lowest slot wins
        write_slot(12, 1, 5'd5, 0, 5'd11, 1, 1, 1);
        write_slot(9,  1, 5'd12, 0, 5'd4, 0, 0, 1);
        write_slot(10, 1, 5'd25, 0, 5'd14, 1, 0, 1);
        write_slot(15, 1, 5'd25, 0, 5'd0,  0, 0, 0);
        sweep("R10 config B");

        // R11: clearing slots exposes the next duplicate or the default
        write_slot(0, 0, 5'd5, 0, 5'd7, 1, 0, 0);
        write_slot(10, 0, 5'd0, 0, 5'd0, 0, 0, 0);
        write_slot(2, 0, 5'd12, 0, 5'd31, 1, 1, 0);
        sweep("R11 config C");

        // R2: back-to-back requests keep the strobe high
        @(negedge clk);
        lk_req = 1'b1; lk_key = 5'd5; lk_is_fp = 1'b1;
        @(negedge clk);
        check("R2 back-to-back first", {31'd0, rsp_valid}, 32'd1);
        lk_key = 5'd6;
        @(negedge clk);
        lk_req = 1'b0;
        check("R2 back-to-back second", {31'd0, rsp_valid}, 32'd1);
        check("R3 back-to-back miss mask", rsp_mask, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R2 strobe drops", {31'd0, rsp_valid}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule